// File: doc/BRIEF.md
# Sixteen-bit timer/counter with byte-wide register access

This block is a 16-bit up-counter with two compare registers and a programmable top register, all reached from an 8-bit data bus. A single shared holding byte makes 16-bit transfers atomic. A write to a high byte only loads the holding byte. The following write to the matching low byte then commits all sixteen bits at once. A read of a low byte returns the live low half and copies the live high half into the holding byte. A later read of the high byte returns that copy, so software sees one coherent 16-bit snapshot even while the counter runs.

The counter advances on each cycle in which `tick_en` is high; a prescaler is expected outside. It has three wrap behaviours: free running to 0xFFFF, clearing after it equals the top register, and a 10-bit wrap at 0x3FF. Matches against compare A and compare B set flags. A compare-B match can also invert a waveform output. Flags combined with a mask drive three interrupt requests.

The wrap behaviour is held in an enumerated mode register (`MODE_FREE`, `MODE_TOPREG`, `MODE_PWM10`; the spare code acts as `MODE_FREE`). Each counting cycle takes one of two transitions: *advance*, where the count goes up by one, or *wrap*, where the count returns to 0 because the current count equals the top value of the selected mode. A write to the count low byte overrides both transitions.

Top module: `tmr16_core`

## Requirements
- R1: After reset, all registers read 0: the count, both compares, top, the holding byte, mode, mask and flags. `wave_b`, `wave_b_oe` and all interrupt requests are low.
- R2: The register map is as follows. Addresses 0/1 are count low/high, 2/3 compare A, 4/5 compare B, 6/7 top. Address 8 is control (bits 1:0 mode, bit 2 toggle enable), 9 is the interrupt mask and 10 is the flags. Writing an odd address 0–7 changes only the holding byte. Writing an even address 0–7 loads {holding byte, data} into that register in one edge.
- R3: Writing the count low byte with 0x22 and then the count high byte with 0x55, from reset, leaves the count at 0x0022.
- R4: Reading an even address 0–7 returns the live low byte and latches the live high byte into the holding byte. Reading an odd address 0–7 returns the holding byte. A high-then-low read just after a wrap from 0xFFFF therefore gives 0xFF then 0x00.
- R5: In mode 0, the count runs up to 0xFFFF and wraps to 0. The wrap sets flag bit 0 (overflow).
- R6: On a counting cycle whose new count equals compare A, flag bit 1 is set. If the new count equals compare B, flag bit 2 is set.
- R7: In mode 1, a counting cycle starting at a count equal to top clears the count to 0 and sets no overflow flag, unless that count is 0xFFFF.
- R8: In mode 2, a counting cycle starting at 0x3FF clears the count to 0 and sets the overflow flag.
- R9: While control bit 2 is set, `wave_b_oe` is high and `wave_b` inverts on each compare-B hit. At all other times `wave_b` holds its value.
- R10: Each interrupt request is the matching flag AND the matching mask bit (same bit order as the flags). Writing 1 to a flag bit clears it. A flag being set in the same cycle wins over the clear.
- R11: While `tick_en` is low, the count holds its value.
- R12: A count low-byte write in a cycle with `tick_en` high loads the written value with no increment.
- R13: All registers share one holding byte. A count high write, then a compare-A high write, then a count low write of 0x01 gives a count of 0xBB01 when the second high write was 0xBB.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Count enable for this cycle |
| wr_en | input | 1 | Bus write strobe |
| rd_en | input | 1 | Bus read strobe |
| addr | input | 4 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational from addr |
| wave_b | output | 1 | Toggle-on-compare-B waveform |
| wave_b_oe | output | 1 | Waveform drive enable |
| irq_ovf | output | 1 | Overflow interrupt request |
| irq_cmpa | output | 1 | Compare A interrupt request |
| irq_cmpb | output | 1 | Compare B interrupt request |

## Verification
Read data is combinational and is checked in the same cycle as the strobe. The holding-byte latch, register commits, count steps, flags and the waveform output all take effect on the next clock edge and are checked one cycle later. The bench drives all inputs at the falling edge and compares a behavioural model against every output a quarter period later. The model updates at the rising edge from the same inputs. Directed sequences then read back through the bus, so every result is observed at the edge where the requirements place it.

// File: rtl/tmr16_pkg.sv
package tmr16_pkg;
    typedef enum logic [1:0] {
        MODE_FREE   = 2'd0,
        MODE_TOPREG = 2'd1,
        MODE_PWM10  = 2'd2,
        MODE_SPARE  = 2'd3
    } mode_e;

    localparam int ADDR_W  = 4;
    localparam int NFLAG   = 3;
    localparam int NREG16  = 3;

    localparam logic [ADDR_W-1:0] A_CNT_LO = 4'd0;
    localparam logic [ADDR_W-1:0] A_CTRL   = 4'd8;
    localparam logic [ADDR_W-1:0] A_MASK   = 4'd9;
    localparam logic [ADDR_W-1:0] A_FLAG   = 4'd10;

    localparam int F_OVF  = 0;
    localparam int F_CMPA = 1;
    localparam int F_CMPB = 2;
endpackage

// File: rtl/tmr16_bus.sv
module tmr16_bus
    import tmr16_pkg::*;
#(
    parameter int BYTE_W = 8,
    localparam int CNT_W = 2 * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] rdata,
    input  logic [CNT_W-1:0]  cnt,
    input  logic [NFLAG-1:0]  flags,
    output logic              cnt_load,
    output logic [CNT_W-1:0]  load_val,
    output logic [CNT_W-1:0]  cmpa,
    output logic [CNT_W-1:0]  cmpb,
    output logic [CNT_W-1:0]  top,
    output mode_e             mode,
    output logic              tog_en,
    output logic [NFLAG-1:0]  mask,
    output logic [NFLAG-1:0]  flag_clr
);
    logic [BYTE_W-1:0] temp_q;
    logic [CNT_W-1:0]  hold [NREG16];
    logic [CNT_W-1:0]  live [NREG16+1];
    logic              in_pair;
    logic              is_hi;
    logic [1:0]        sel;

    assign in_pair  = !addr[ADDR_W-1];
    assign is_hi    = addr[0];
    assign sel      = addr[2:1];
    assign load_val = {temp_q, wdata};
    assign cnt_load = wr_en && (addr == A_CNT_LO);
    assign flag_clr = (wr_en && addr == A_FLAG) ? wdata[NFLAG-1:0] : '0;

    assign live[0] = cnt;

    for (genvar i = 0; i < NREG16; i++) begin : g_reg
        logic [CNT_W-1:0] val_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                val_q <= '0;
            else if (wr_en && in_pair && !is_hi && sel == 2'(i + 1))
                val_q <= {temp_q, wdata};
        end
        assign hold[i]   = val_q;
        assign live[i+1] = val_q;
    end

    assign cmpa = hold[0];
    assign cmpb = hold[1];
    assign top  = hold[2];

    // shared holding byte: high writes load it, low reads snapshot into it
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            temp_q <= '0;
        else if (wr_en && in_pair && is_hi)
            temp_q <= wdata;
        else if (rd_en && !wr_en && in_pair && !is_hi)
            temp_q <= live[sel][CNT_W-1:BYTE_W];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode   <= MODE_FREE;
            tog_en <= 1'b0;
            mask   <= '0;
        end else if (wr_en && addr == A_CTRL) begin
            mode   <= mode_e'(wdata[1:0]);
            tog_en <= wdata[2];
        end else if (wr_en && addr == A_MASK) begin
            mask   <= wdata[NFLAG-1:0];
        end
    end

    always_comb begin
        rdata = '0;
        if (in_pair)
            rdata = is_hi ? temp_q : live[sel][BYTE_W-1:0];
        else if (addr == A_CTRL)
            rdata = BYTE_W'({tog_en, mode});
        else if (addr == A_MASK)
            rdata = BYTE_W'(mask);
        else if (addr == A_FLAG)
            rdata = BYTE_W'(flags);
    end

    AST_HI_WRITE_TEMP: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && in_pair && is_hi) |=> temp_q == $past(wdata)); // R2
    AST_LO_READ_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !wr_en && addr == A_CNT_LO) |=> temp_q == $past(cnt[CNT_W-1:BYTE_W])); // R4
endmodule

// File: rtl/tmr16_count.sv
module tmr16_count
    import tmr16_pkg::*;
#(
    parameter int BYTE_W   = 8,
    parameter int PWM_BITS = 10,
    localparam int CNT_W   = 2 * BYTE_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  mode_e            mode,
    input  logic [CNT_W-1:0] top,
    input  logic [CNT_W-1:0] cmpa,
    input  logic [CNT_W-1:0] cmpb,
    input  logic [NFLAG-1:0] flag_clr,
    output logic [CNT_W-1:0] cnt,
    output logic [NFLAG-1:0] flags,
    output logic             hit_b
);
    localparam logic [CNT_W-1:0] PWM_TOP = CNT_W'((1 << PWM_BITS) - 1);
    localparam logic [CNT_W-1:0] MAXV    = {CNT_W{1'b1}};

    logic             step;
    logic             at_top;
    logic [CNT_W-1:0] nxt;
    logic [NFLAG-1:0] set_ev;

    assign step = tick && !load;

    // wrap transition selection per mode
    always_comb begin
        unique case (mode)
            MODE_FREE:   at_top = (cnt == MAXV);
            MODE_TOPREG: at_top = (cnt == top);
            MODE_PWM10:  at_top = (cnt == PWM_TOP);
            MODE_SPARE:  at_top = (cnt == MAXV);
        endcase
        nxt = at_top ? '0 : cnt + 1'b1;
    end

    always_comb begin
        set_ev         = '0;
        set_ev[F_OVF]  = step && (cnt == MAXV || (mode == MODE_PWM10 && cnt == PWM_TOP));
        set_ev[F_CMPA] = step && (nxt == cmpa);
        set_ev[F_CMPB] = step && (nxt == cmpb);
    end

    assign hit_b = set_ev[F_CMPB];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (step)
            cnt <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            flags <= '0;
        else
            flags <= (flags & ~flag_clr) | set_ev;
    end

    AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> cnt == $past(load_val)); // R12
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !load) |=> $stable(cnt)); // R11
    AST_TOPREG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (step && mode == MODE_TOPREG && cnt == top && cnt != MAXV && flag_clr == '0
         && !flags[F_OVF]) |=> (cnt == '0 && !flags[F_OVF])); // R7
    AST_PWM_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (step && mode == MODE_PWM10 && cnt == PWM_TOP) |=> (cnt == '0 && flags[F_OVF])); // R8
endmodule

// File: rtl/tmr16_wave.sv
module tmr16_wave (
    input  logic clk,
    input  logic rst_n,
    input  logic hit_b,
    input  logic tog_en,
    output logic wave
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            wave <= 1'b0;
        else if (hit_b && tog_en)
            wave <= !wave;
    end

    AST_WAVE_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
        !(hit_b && tog_en) |=> $stable(wave)); // R9
    AST_WAVE_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_b && tog_en) |=> wave != $past(wave)); // R9
endmodule

// File: rtl/tmr16_core.sv
module tmr16_core
    import tmr16_pkg::*;
#(
    parameter int BYTE_W   = 8,
    parameter int PWM_BITS = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] rdata,
    output logic              wave_b,
    output logic              wave_b_oe,
    output logic              irq_ovf,
    output logic              irq_cmpa,
    output logic              irq_cmpb
);
    localparam int CNT_W = 2 * BYTE_W;

    logic [CNT_W-1:0] cnt, load_val, cmpa, cmpb, top;
    logic [NFLAG-1:0] flags, mask, flag_clr;
    logic             cnt_load, tog_en, hit_b;
    mode_e            mode;

    tmr16_bus #(.BYTE_W(BYTE_W)) u_bus (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .cnt(cnt), .flags(flags),
        .cnt_load(cnt_load), .load_val(load_val), .cmpa(cmpa), .cmpb(cmpb),
        .top(top), .mode(mode), .tog_en(tog_en), .mask(mask), .flag_clr(flag_clr)
    );

    tmr16_count #(.BYTE_W(BYTE_W), .PWM_BITS(PWM_BITS)) u_count (
        .clk(clk), .rst_n(rst_n), .tick(tick_en), .load(cnt_load),
        .load_val(load_val), .mode(mode), .top(top), .cmpa(cmpa), .cmpb(cmpb),
        .flag_clr(flag_clr), .cnt(cnt), .flags(flags), .hit_b(hit_b)
    );

    tmr16_wave u_wave (
        .clk(clk), .rst_n(rst_n), .hit_b(hit_b), .tog_en(tog_en), .wave(wave_b)
    );

    assign wave_b_oe = tog_en;
    assign irq_ovf   = flags[F_OVF]  && mask[F_OVF];
    assign irq_cmpa  = flags[F_CMPA] && mask[F_CMPA];
    assign irq_cmpb  = flags[F_CMPB] && mask[F_CMPB];

    AST_FLAG_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == A_FLAG && tick_en && hit_b) |=> flags[F_CMPB]); // R10
endmodule

// File: tb/tmr16_core_test.sv
module tmr16_core_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_en = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
    logic [3:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       wave_b, wave_b_oe, irq_ovf, irq_cmpa, irq_cmpb;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #4 clk = !clk;

    tmr16_core uut (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .wave_b(wave_b),
        .wave_b_oe(wave_b_oe), .irq_ovf(irq_ovf), .irq_cmpa(irq_cmpa), .irq_cmpb(irq_cmpb)
    );

    // behavioural reference model
    int m_cnt = 0, m_cmpa = 0, m_cmpb = 0, m_top = 0, m_tmp = 0;
    int m_ctrl = 0, m_mask = 0, m_flags = 0, m_wave = 0;

    function automatic int reg_of(int idx);
        case (idx)
            0: return m_cnt;
            1: return m_cmpa;
            2: return m_cmpb;
            default: return m_top;
        endcase
    endfunction

    function automatic int m_rd(int a);
        if (a < 8) return (a % 2 == 1) ? m_tmp : (reg_of(a / 2) & 255);
        if (a == 8) return m_ctrl;
        if (a == 9) return m_mask;
        if (a == 10) return m_flags;
        return 0;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_cmpa = 0; m_cmpb = 0; m_top = 0; m_tmp = 0;
            m_ctrl = 0; m_mask = 0; m_flags = 0; m_wave = 0;
        end else begin
            int a, d, nxt, set, clr, md;
            bit wrap, step;
            a = int'(addr); d = int'(wdata); set = 0; clr = 0; md = m_ctrl & 3;
            step = tick_en && !(wr_en && a == 0);
            nxt = m_cnt;
            if (step) begin
                if (md == 1) wrap = (m_cnt == m_top);
                else if (md == 2) wrap = (m_cnt == 1023);
                else wrap = (m_cnt == 65535);
                nxt = wrap ? 0 : (m_cnt + 1) & 65535;
                if (m_cnt == 65535 || (md == 2 && m_cnt == 1023)) set |= 1;
                if (nxt == m_cmpa) set |= 2;
                if (nxt == m_cmpb) begin
                    set |= 4;
                    if ((m_ctrl & 4) != 0) m_wave ^= 1;
                end
            end
            if (wr_en) begin
                if (a < 8 && a % 2 == 1) m_tmp = d;
                else if (a == 0) nxt = m_tmp * 256 + d;
                else if (a == 2) m_cmpa = m_tmp * 256 + d;
                else if (a == 4) m_cmpb = m_tmp * 256 + d;
                else if (a == 6) m_top = m_tmp * 256 + d;
                else if (a == 8) m_ctrl = d & 7;
                else if (a == 9) m_mask = d & 7;
                else if (a == 10) clr = d & 7;
            end else if (rd_en && a < 8 && a % 2 == 0) begin
                m_tmp = (reg_of(a / 2) >> 8) & 255;
            end
            m_cnt = nxt;
            m_flags = (m_flags & ~clr) | set;
        end
    end

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // model comparison every clock, away from both edges
    always @(negedge clk) begin
        #2;
        if (rst_n && !done) begin
            chk("R4 rdata vs model", int'(rdata), m_rd(int'(addr)));
            chk("R9 wave_b vs model", int'(wave_b), m_wave);
            chk("R9 wave_b_oe vs model", int'(wave_b_oe), (m_ctrl >> 2) & 1);
            chk("R10 irq vs model", int'({irq_cmpb, irq_cmpa, irq_ovf}), m_flags & m_mask);
        end
    end

    task automatic acc(bit t, bit w, bit r, int a, int d);
        tick_en = t; wr_en = w; rd_en = r; addr = 4'(a); wdata = 8'(d);
        @(posedge clk); @(negedge clk);
        tick_en = 0; wr_en = 0; rd_en = 0;
    endtask

    task automatic wr(int a, int d); acc(0, 1, 0, a, d); endtask
    task automatic tk(); acc(1, 0, 0, 12, 0); endtask

    task automatic rd(int a, output int v);
        tick_en = 0; wr_en = 0; rd_en = 1; addr = 4'(a);
        #1 v = int'(rdata);
        @(posedge clk); @(negedge clk);
        rd_en = 0;
    endtask

    task automatic set_cnt(int v); wr(1, v >> 8); wr(0, v & 255); endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int v;
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1 reset state
        rd(0, v); chk("R1 count low", v, 0);
        rd(1, v); chk("R1 count high", v, 0);
        rd(8, v); chk("R1 control", v, 0);
        rd(10, v); chk("R1 flags", v, 0);
        chk("R1 wave_b", int'(wave_b), 0);
        chk("R1 irq", int'({irq_cmpb, irq_cmpa, irq_ovf}), 0);
        // R3 low then high
        wr(0, 8'h22); wr(1, 8'h55);
        rd(0, v); chk("R3 low", v, 8'h22);
        rd(1, v); chk("R3 high", v, 8'h00);
        // R2 high write alone, then commit
        wr(1, 8'h12);
        rd(0, v); chk("R2 high write only temp", v, 8'h22);
        wr(1, 8'h12); wr(0, 8'h34);
        rd(0, v); chk("R2 commit low", v, 8'h34);
        rd(1, v); chk("R2 commit high", v, 8'h12);
        // R11 no tick
        repeat (4) acc(0, 0, 0, 12, 0);
        rd(0, v); chk("R11 hold", v, 8'h34);
        // R12 write during tick
        wr(1, 8'h12);
        acc(1, 1, 0, 0, 8'h40);
        rd(0, v); chk("R12 low", v, 8'h40);
        rd(1, v); chk("R12 high", v, 8'h12);
        // R5 / R4 wrap and stale high read
        set_cnt(16'hFFFF);
        tk();
        rd(1, v); chk("R4 stale high", v, 8'hFF);
        rd(0, v); chk("R5 wrapped low", v, 8'h00);
        rd(1, v); chk("R4 fresh high", v, 8'h00);
        rd(10, v); chk("R5 overflow flag", v & 1, 1);
        wr(10, 7);
        rd(10, v); chk("R10 clear", v, 0);
        // R6 compare A then B
        wr(3, 8'h10); wr(2, 8'hEF);
        set_cnt(16'h10EE); tk();
        rd(10, v); chk("R6 compare A", v, 2);
        wr(5, 8'h10); wr(4, 8'hF0);
        tk();
        rd(10, v); chk("R6 compare B", v, 6);
        wr(10, 7);
        // R7 top-register mode
        wr(8, 1); wr(7, 8'h50); wr(6, 8'h10);
        set_cnt(16'h500F); tk(); tk();
        rd(0, v); chk("R7 low", v, 0);
        rd(1, v); chk("R7 high", v, 0);
        rd(10, v); chk("R7 no overflow", v, 0);
        // R8 10-bit wrap
        wr(8, 2); set_cnt(16'h03FF); tk();
        rd(0, v); chk("R8 low", v, 0);
        rd(1, v); chk("R8 high", v, 0);
        rd(10, v); chk("R8 overflow", v & 1, 1);
        wr(10, 7);
        // R9 toggle on compare B
        wr(8, 4);
        chk("R9 oe", int'(wave_b_oe), 1);
        wr(5, 0); wr(4, 8'h4A);
        set_cnt(16'h0049);
        chk("R9 before hit", int'(wave_b), 0);
        tk(); chk("R9 toggled", int'(wave_b), 1);
        tk(); chk("R9 held", int'(wave_b), 1);
        wr(10, 7);
        // R10 masked interrupts and set-wins
        wr(9, 1);
        set_cnt(16'hFFFF); tk();
        chk("R10 irq_ovf", int'(irq_ovf), 1);
        chk("R10 irq_cmpa masked", int'(irq_cmpa), 0);
        wr(10, 1); chk("R10 cleared", int'(irq_ovf), 0);
        set_cnt(16'hFFFF);
        acc(1, 1, 0, 10, 1);
        chk("R10 set wins", int'(irq_ovf), 1);
        wr(10, 7);
        // R13 shared holding byte interleave
        wr(1, 8'hAA); wr(3, 8'hBB); wr(0, 8'h01);
        rd(0, v); chk("R13 low", v, 8'h01);
        rd(1, v); chk("R13 high", v, 8'hBB);
        // free run against the model
        wr(8, 4); wr(9, 7);
        for (int i = 0; i < 400; i++) begin
            if (i % 37 == 5) wr(1 + 2 * (i % 3), i & 255);
            else if (i % 11 == 0) rd(2 * (i % 4), v);
            else acc(i % 3 != 0, 0, 0, 10, 0);
        end
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule